// File: doc/BRIEF.md
# Synthetic Traffic Pattern Generator

This block produces packet-injection requests for one source node of an on-chip network under test. Every cycle in which its output slot is free, it decides whether to create a new request. The decision compares a pseudo-random value against a programmable load threshold. When a request is created, its destination comes from the node's own address through one of six selectable permutations. One of these permutations uses a random destination instead.

Requests leave through a valid/ready handshake. A request that has been raised stays on the port with a frozen destination until the consumer takes it. A running count of accepted packets is kept on an output. The node address width is a parameter and must be even so that the two halves of the address can be exchanged. The pattern select is sampled only while no request is outstanding. A request whose destination would equal the source is never raised.

Top module: `tpg_gen`

## Requirements
- R1: After reset `pkt_valid` is low, `pkt_count` is zero and the internal Galois LFSR holds the nonzero `SEED`.
- R2: In any cycle where the slot is free (`pkt_valid` low or `pkt_ready` high), a request is raised at the next edge only if the upper `LOAD_W` bits of the LFSR are numerically below `load_thr`. A `load_thr` of 0 never injects, and 128 (of 8 bits) injects on roughly half the free cycles.
- R3: Pattern code 0 (uniform) takes the low `ADDR_W` bits of the LFSR as the destination, so that over many packets every address other than the source appears.
- R4: Pattern code 1 reverses the bit order of the source address.
- R5: Pattern code 2 exchanges the most and least significant address bits and keeps all other bits.
- R6: Pattern code 3 inverts every bit of the source address.
- R7: Pattern code 4 rotates the source address left by one bit.
- R8: Pattern code 5 exchanges the upper and lower halves of the source address.
- R9: Pattern codes 6 and 7 are reserved and raise no request.
- R10: A request whose computed destination equals `src_addr` is suppressed. No packet is ever addressed to its own source.
- R11: While `pkt_valid` is high and `pkt_ready` is low, `pkt_valid` stays high and `pkt_dest` stays unchanged.
- R12: `pkt_count` increases by one for each cycle with `pkt_valid` and `pkt_ready` both high, and holds in every other cycle.
- R13: A change of `mode_sel` is taken into the active pattern only in a cycle with `pkt_valid` low. A pending request keeps the destination of the earlier pattern.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_addr | input | ADDR_W | Address of this source node |
| mode_sel | input | 3 | Pattern code (0..5 active, 6..7 reserved) |
| load_thr | input | LOAD_W | Injection threshold against the random value |
| pkt_ready | input | 1 | Consumer accepts the request this cycle |
| pkt_valid | output | 1 | A request is offered |
| pkt_dest | output | ADDR_W | Destination of the offered request |
| pkt_count | output | CNT_W | Number of accepted packets since reset |

## Verification
A wrong latched pattern shows at the ports on the first request raised after the fault. That request carries a destination that does not match the permutation of the source address, so an exact comparison of each accepted destination finds it within one packet. A bad handshake register shows within one cycle of backpressure, either as a dropped request or as a destination that changes while stalled. A stuck or short-cycle random source shows more slowly, over hundreds of cycles. It appears as an injection rate far from the threshold fraction or as uniform-mode destinations that never visit part of the address space.

// File: rtl/tpg_pkg.sv
package tpg_pkg;

   typedef enum logic [2:0] {
      PAT_UNIFORM  = 3'd0,
      PAT_BITREV   = 3'd1,
      PAT_ENDSWAP  = 3'd2,
      PAT_INVERT   = 3'd3,
      PAT_ROTL     = 3'd4,
      PAT_HALFSWAP = 3'd5,
      PAT_RSV6     = 3'd6,
      PAT_RSV7     = 3'd7
   } pat_e;

   // Galois right-shift feedback masks for maximal-length sequences
   function automatic logic [63:0] lfsr_mask(input int width);
      case (width)
         8:       return 64'h0000_0000_0000_00B8;
         16:      return 64'h0000_0000_0000_B400;
         24:      return 64'h0000_0000_00E1_0000;
         32:      return 64'h0000_0000_8020_0003;
         default: return 64'h0;
      endcase
   endfunction

   function automatic bit lfsr_width_ok(input int width);
      return (width == 8) || (width == 16) || (width == 24) || (width == 32);
   endfunction

endpackage

// File: rtl/tpg_lfsr.sv
module tpg_lfsr #(
   parameter int          W    = 16,
   parameter logic [63:0] SEED = 64'hACE1
) (
   input  logic         clk,
   input  logic         rst_n,
   output logic [W-1:0] state
);
   import tpg_pkg::*;

   localparam logic [W-1:0] MASK     = W'(lfsr_mask(W));
   localparam logic [W-1:0] SEED_W   = W'(SEED);

   if (!lfsr_width_ok(W)) begin : g_bad_width
      $error("tpg_lfsr: unsupported width");
   end
   if (SEED_W == '0) begin : g_bad_seed
      $error("tpg_lfsr: seed must be nonzero");
   end

   logic [W-1:0] nxt;

   always_comb begin
      nxt = state >> 1;
      if (state[0]) nxt = nxt ^ MASK;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state <= SEED_W;
      else        state <= nxt;
   end

endmodule

// File: rtl/tpg_gate.sv
module tpg_gate #(
   parameter int LFSR_W = 16,
   parameter int LOAD_W = 8
) (
   input  logic [LFSR_W-1:0] rnd,
   input  logic [LOAD_W-1:0] load_thr,
   output logic              inject
);
   localparam int TOP = LFSR_W - 1;

   if (LOAD_W > LFSR_W || LOAD_W < 1) begin : g_bad_load
      $error("tpg_gate: LOAD_W must be between 1 and LFSR_W");
   end

   logic [LOAD_W-1:0] sample;
   assign sample = rnd[TOP -: LOAD_W];
   assign inject = (sample < load_thr);

endmodule

// File: rtl/tpg_permute.sv
module tpg_permute #(
   parameter int ADDR_W = 6,
   parameter int LFSR_W = 16
) (
   input  tpg_pkg::pat_e      mode,
   input  logic [ADDR_W-1:0]  src,
   input  logic [LFSR_W-1:0]  rnd,
   output logic [ADDR_W-1:0]  dest,
   output logic               pat_ok
);
   import tpg_pkg::*;

   localparam int HALF = ADDR_W / 2;
   localparam int MSB  = ADDR_W - 1;

   if (ADDR_W < 2 || (ADDR_W % 2) != 0) begin : g_bad_addr
      $error("tpg_permute: ADDR_W must be even and at least 2");
   end
   if (LFSR_W < ADDR_W) begin : g_bad_rnd
      $error("tpg_permute: LFSR_W must cover ADDR_W");
   end

   logic [ADDR_W-1:0] d_rev, d_end, d_inv, d_rot, d_half, d_uni;

   for (genvar i = 0; i < ADDR_W; i++) begin : g_rev
      assign d_rev[i] = src[MSB-i];
   end

   for (genvar i = 0; i < ADDR_W; i++) begin : g_end
      if (i == 0) begin : g_lo
         assign d_end[i] = src[MSB];
      end else if (i == MSB) begin : g_hi
         assign d_end[i] = src[0];
      end else begin : g_mid
         assign d_end[i] = src[i];
      end
   end

   for (genvar i = 0; i < ADDR_W; i++) begin : g_rot
      assign d_rot[i] = src[(i + MSB) % ADDR_W];
   end

   for (genvar i = 0; i < ADDR_W; i++) begin : g_half
      assign d_half[i] = src[(i + HALF) % ADDR_W];
   end

   assign d_inv = ~src;
   assign d_uni = rnd[ADDR_W-1:0];

   always_comb begin
      pat_ok = 1'b1;
      unique case (mode)
         PAT_UNIFORM:  dest = d_uni;
         PAT_BITREV:   dest = d_rev;
         PAT_ENDSWAP:  dest = d_end;
         PAT_INVERT:   dest = d_inv;
         PAT_ROTL:     dest = d_rot;
         PAT_HALFSWAP: dest = d_half;
         default: begin
            dest   = '0;
            pat_ok = 1'b0;
         end
      endcase
   end

endmodule

// File: rtl/tpg_issue.sv
module tpg_issue #(
   parameter int ADDR_W = 6,
   parameter int CNT_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fire,
   input  logic [ADDR_W-1:0] cand_dest,
   input  logic              pkt_ready,
   output logic              pkt_valid,
   output logic [ADDR_W-1:0] pkt_dest,
   output logic [CNT_W-1:0]  pkt_count,
   output logic              slot_free
);
   logic accept;

   assign slot_free = !pkt_valid || pkt_ready;
   assign accept    = pkt_valid && pkt_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pkt_valid <= 1'b0;
         pkt_dest  <= '0;
      end else if (slot_free) begin
         pkt_valid <= fire;
         if (fire) pkt_dest <= cand_dest;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      pkt_count <= '0;
      else if (accept) pkt_count <= pkt_count + 1'b1;
   end

endmodule

// File: rtl/tpg_gen.sv
module tpg_gen #(
   parameter int          ADDR_W = 6,
   parameter int          LFSR_W = 16,
   parameter int          LOAD_W = 8,
   parameter int          CNT_W  = 16,
   parameter logic [63:0] SEED   = 64'hACE1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] src_addr,
   input  logic [2:0]        mode_sel,
   input  logic [LOAD_W-1:0] load_thr,
   input  logic              pkt_ready,
   output logic              pkt_valid,
   output logic [ADDR_W-1:0] pkt_dest,
   output logic [CNT_W-1:0]  pkt_count
);
   import tpg_pkg::*;

   if (CNT_W < 1) begin : g_bad_cnt
      $error("tpg_gen: CNT_W must be positive");
   end

   logic [LFSR_W-1:0] rnd;
   logic              inject;
   logic [ADDR_W-1:0] cand_dest;
   logic              pat_ok;
   logic              slot_free;
   logic              fire;
   pat_e              mode_q;

   // pattern select is latched only while nothing is outstanding
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          mode_q <= PAT_UNIFORM;
      else if (!pkt_valid) mode_q <= pat_e'(mode_sel);
   end

   tpg_lfsr #(.W(LFSR_W), .SEED(SEED)) u_lfsr (
      .clk   (clk),
      .rst_n (rst_n),
      .state (rnd)
   );

   tpg_gate #(.LFSR_W(LFSR_W), .LOAD_W(LOAD_W)) u_gate (
      .rnd      (rnd),
      .load_thr (load_thr),
      .inject   (inject)
   );

   tpg_permute #(.ADDR_W(ADDR_W), .LFSR_W(LFSR_W)) u_perm (
      .mode   (mode_q),
      .src    (src_addr),
      .rnd    (rnd),
      .dest   (cand_dest),
      .pat_ok (pat_ok)
   );

   assign fire = inject && pat_ok && (cand_dest != src_addr);

   tpg_issue #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_issue (
      .clk       (clk),
      .rst_n     (rst_n),
      .fire      (fire),
      .cand_dest (cand_dest),
      .pkt_ready (pkt_ready),
      .pkt_valid (pkt_valid),
      .pkt_dest  (pkt_dest),
      .pkt_count (pkt_count),
      .slot_free (slot_free)
   );

endmodule

// File: rtl/tpg_gen_chk.sv
module tpg_gen_chk #(
   parameter int ADDR_W = 6,
   parameter int LOAD_W = 8,
   parameter int CNT_W  = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] src_addr,
   input logic [2:0]        mode_sel,
   input logic [LOAD_W-1:0] load_thr,
   input logic              pkt_ready,
   input logic              pkt_valid,
   input logic [ADDR_W-1:0] pkt_dest,
   input logic [CNT_W-1:0]  pkt_count,
   input logic [2:0]        mode_q
);
   logic free_now;
   assign free_now = !pkt_valid || pkt_ready;

   a_r2_zero_load: assert property (@(posedge clk) disable iff (!rst_n)
      (load_thr == '0) && free_now |=> !pkt_valid);

   a_r9_reserved_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q[2:1] == 2'b11) && free_now |=> !pkt_valid);

   a_r10_no_self: assert property (@(posedge clk) disable iff (!rst_n)
      $past(!pkt_valid || pkt_ready) && pkt_valid && $stable(src_addr)
      |-> pkt_dest != src_addr);

   a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
      pkt_valid && !pkt_ready |=> pkt_valid && $stable(pkt_dest));

   a_r12_count_step: assert property (@(posedge clk) disable iff (!rst_n)
      pkt_valid && pkt_ready |=> pkt_count == CNT_W'($past(pkt_count) + 1'b1));

   a_r12_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !(pkt_valid && pkt_ready) |=> $stable(pkt_count));

   a_r13_mode_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      pkt_valid |=> $stable(mode_q));

endmodule

bind tpg_gen tpg_gen_chk #(.ADDR_W(ADDR_W), .LOAD_W(LOAD_W), .CNT_W(CNT_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .src_addr  (src_addr),
   .mode_sel  (mode_sel),
   .load_thr  (load_thr),
   .pkt_ready (pkt_ready),
   .pkt_valid (pkt_valid),
   .pkt_dest  (pkt_dest),
   .pkt_count (pkt_count),
   .mode_q    (mode_q)
);

// File: tb/test_tpg_gen.sv
module test_tpg_gen;
   localparam int AW = 6;
   localparam int LW = 8;
   localparam int CW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] src_addr = 6'd13;
   logic [2:0]    mode_sel = 3'd0;
   logic [LW-1:0] load_thr = '0;
   logic          pkt_ready = 1'b0;
   logic          pkt_valid;
   logic [AW-1:0] pkt_dest;
   logic [CW-1:0] pkt_count;

   int n_chk = 0;
   int n_bad = 0;
   int total_acc = 0;

   always #2.5 clk = ~clk;

   tpg_gen #(.ADDR_W(AW), .LOAD_W(LW), .CNT_W(CW)) i_tpg_gen (
      .clk(clk), .rst_n(rst_n), .src_addr(src_addr), .mode_sel(mode_sel),
      .load_thr(load_thr), .pkt_ready(pkt_ready), .pkt_valid(pkt_valid),
      .pkt_dest(pkt_dest), .pkt_count(pkt_count)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic logic [AW-1:0] expect_dest(input int m, input logic [AW-1:0] s);
      logic [AW-1:0] r;
      r = s;
      case (m)
         1: for (int i = 0; i < AW; i++) r[i] = s[AW-1-i];
         2: begin r[0] = s[AW-1]; r[AW-1] = s[0]; end
         3: r = ~s;
         4: r = {s[AW-2:0], s[AW-1]};
         5: r = {s[AW/2-1:0], s[AW-1:AW/2]};
         default: r = s;
      endcase
      return r;
   endfunction

   // one cycle: record the handshake the coming edge will see
   task automatic tick(output bit hs, output logic [AW-1:0] d);
      hs = pkt_valid && pkt_ready;
      d  = pkt_dest;
      if (hs) total_acc++;
      @(negedge clk);
   endtask

   task automatic idle(input int n);
      bit h; logic [AW-1:0] d;
      for (int i = 0; i < n; i++) tick(h, d);
   endtask

   task automatic settle(input int m);
      load_thr = '0; pkt_ready = 1'b1;
      idle(4);
      mode_sel = 3'(m);
      idle(2);
   endtask

   task automatic check_count(input string req);
      pkt_ready = 1'b0;
      idle(1);
      check(pkt_count == CW'(total_acc), req, pkt_count, total_acc);
   endtask

   task automatic t_reset;
      check(!pkt_valid, "R1 valid after reset", pkt_valid, 0);
      check(pkt_count == 0, "R1 count after reset", pkt_count, 0);
   endtask

   task automatic t_zero_load;
      int seen = 0;
      settle(1);
      load_thr = '0; pkt_ready = 1'b1;
      for (int i = 0; i < 200; i++) begin
         if (pkt_valid) seen++;
         idle(1);
      end
      check(seen == 0, "R2 zero load raises nothing", seen, 0);
   endtask

   task automatic t_pattern(input int m, input string req);
      int acc = 0, bad = 0, first_bad = 0;
      bit h; logic [AW-1:0] d, e;
      settle(m);
      e = expect_dest(m, src_addr);
      load_thr = 8'd255; pkt_ready = 1'b1;
      for (int i = 0; i < 300; i++) begin
         tick(h, d);
         if (h) begin
            acc++;
            if (d != e) begin bad++; first_bad = d; end
         end
      end
      check(acc > 200, req, acc, 200);
      check(bad == 0, req, first_bad, e);
      check_count("R12 count after pattern run");
   endtask

   task automatic t_rate;
      int acc = 0;
      bit h; logic [AW-1:0] d;
      settle(1);
      load_thr = 8'd128; pkt_ready = 1'b1;
      for (int i = 0; i < 1000; i++) begin tick(h, d); if (h) acc++; end
      check(acc >= 350 && acc <= 650, "R2 half load rate", acc, 500);
      check_count("R12 count after rate run");
   endtask

   task automatic t_uniform;
      bit seen [64];
      int self_hits = 0, missing = 0;
      bit h; logic [AW-1:0] d;
      for (int i = 0; i < 64; i++) seen[i] = 1'b0;
      settle(0);
      load_thr = 8'd255; pkt_ready = 1'b1;
      for (int i = 0; i < 3000; i++) begin
         tick(h, d);
         if (h) begin
            seen[d] = 1'b1;
            if (d == src_addr) self_hits++;
         end
      end
      for (int i = 0; i < 64; i++) if (i != int'(src_addr) && !seen[i]) missing++;
      check(missing == 0, "R3 uniform covers all other nodes", missing, 0);
      check(self_hits == 0, "R10 uniform never targets source", self_hits, 0);
      check_count("R12 count after uniform run");
   endtask

   task automatic t_reserved(input int m);
      int seen = 0;
      settle(m);
      load_thr = 8'd255; pkt_ready = 1'b1;
      for (int i = 0; i < 200; i++) begin
         if (pkt_valid) seen++;
         idle(1);
      end
      check(seen == 0, "R9 reserved code idle", seen, 0);
   endtask

   task automatic t_self(input int m, input logic [AW-1:0] s);
      int seen = 0;
      settle(m);
      src_addr = s;
      idle(1);
      load_thr = 8'd255; pkt_ready = 1'b1;
      for (int i = 0; i < 200; i++) begin
         if (pkt_valid) seen++;
         idle(1);
      end
      check(seen == 0, "R10 self destination suppressed", seen, 0);
      load_thr = '0;
      idle(2);
      src_addr = 6'd13;
   endtask

   task automatic t_backpressure;
      int guard = 0, moved = 0, dropped = 0;
      logic [AW-1:0] d0;
      logic [CW-1:0] c0;
      settle(1);
      pkt_ready = 1'b0; load_thr = 8'd255;
      while (!pkt_valid && guard < 200) begin idle(1); guard++; end
      check(pkt_valid, "R11 request appears under stall", pkt_valid, 1);
      d0 = pkt_dest; c0 = pkt_count;
      mode_sel = 3'd4;
      for (int i = 0; i < 12; i++) begin
         idle(1);
         if (!pkt_valid) dropped++;
         if (pkt_dest != d0) moved++;
      end
      check(dropped == 0, "R11 valid held while stalled", dropped, 0);
      check(moved == 0, "R11 dest held while stalled", moved, 0);
      check(d0 == expect_dest(1, src_addr), "R13 pending keeps old pattern",
            d0, expect_dest(1, src_addr));
      check(pkt_count == c0, "R12 no count while stalled", pkt_count, c0);
      pkt_ready = 1'b1;
      idle(1);
      check_count("R12 count after single accept");
   endtask

   initial begin
      #(100000 * 5);
      check(1'b0, "watchdog expired", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_zero_load();
      t_pattern(1, "R4 bit reversal");
      t_pattern(2, "R5 end bit swap");
      t_pattern(3, "R6 complement");
      t_pattern(4, "R7 rotate left");
      t_pattern(5, "R8 half swap");
      t_rate();
      t_uniform();
      t_reserved(6);
      t_reserved(7);
      t_self(2, 6'b100101);
      t_self(5, 6'b101101);
      t_self(1, 6'b100001);
      t_backpressure();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule